// File: doc/BRIEF.md
# Streaming Greyscale Histogram Equalizer

This block equalizes the contrast of an 8-bit greyscale raster stream without storing a frame. While frame k streams in, it counts how many pixels fall on each grey level and tracks the brightest value seen. In the idle gap after the frame it sweeps the 256 levels once. It turns the counts into a running cumulative table and clears the counting bank for later use. Frame k+1 is then remapped pixel by pixel through that table. Each result is scaled by the ratio of the brightest grey of frame k to the nominal pixel count of a frame.

Two histogram banks alternate between frames, so the bank being swept is never the one being counted. A controller with four named states runs the block. ST_CLEAR zeroes both banks after reset. ST_WAIT idles between frames. ST_COUNT gathers statistics. ST_BUILD sweeps the levels. The transitions are:
- CLEAR→WAIT after 256 cycles.
- WAIT→COUNT on a valid start-of-frame pixel.
- WAIT→BUILD on a single-pixel frame.
- COUNT→BUILD on a valid end-of-frame pixel.
- BUILD→WAIT after 256 cycles.

Until the first table exists, pixels pass through unchanged.

Top module: `hist_equalizer`

## Requirements
- R1: After reset `out_valid` is low, and the controller spends 256 cycles in ST_CLEAR before it enters ST_WAIT and accepts a frame.
- R2: Every valid input pixel appears on the output exactly 2 clock cycles later, with `out_sof` and `out_eof` copying `in_sof` and `in_eof`; pixels are output in arrival order.
- R3: Until the table of a first complete frame has been built, each output pixel equals its input pixel.
- R4: Once a table exists, a pixel of value v is output as floor((C(v)·P + N/2) / N). Here C(v) is the number of pixels of the previous frame with value less than or equal to v (the level itself included), P is that frame's largest value, and N = FRAME_W·FRAME_H.
- R5: For a previous frame of exactly N pixels, every value at or above its largest value maps to that largest value, and every value below its smallest value maps to 0.
- R6: Only the frame immediately before influences the mapping; counts from earlier frames are cleared by the sweep and never reappear.
- R7: A valid pixel presented in ST_WAIT without `in_sof` is mapped and output but not counted into any histogram.
- R8: A mapped value above 255 is clamped to 255. This can happen when a frame carries more than N pixels.
- R9: ST_BUILD starts on the cycle after the end-of-frame pixel and lasts 256 cycles. A start-of-frame pixel sampled 257 cycles after the end-of-frame pixel of the previous frame is already mapped through the new table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | First pixel of a frame |
| in_eof | input | 1 | Last pixel of a frame |
| in_pix | input | 8 | Input grey value |
| out_valid | output | 1 | Output pixel present this cycle |
| out_sof | output | 1 | First pixel of a frame, delayed |
| out_eof | output | 1 | Last pixel of a frame, delayed |
| out_pix | output | 8 | Equalized grey value |

## Verification
Each pixel of frame k+1 is counted into one bank and, in the same cycle, looked up in the table built from frame k. A faulty design could therefore let a pixel's own count leak into its mapping, or sweep the bank still being filled. The directed frames change their content and brightness from one frame to the next, so a leak or wrong bank moves the expected outputs. The bench also places a start-of-frame pixel at the earliest legal cycle after a sweep, where table write-back and lookup meet. Outputs are judged against a model that keeps only the previous frame's histogram and maximum.

// File: rtl/heq_pkg.sv
package heq_pkg;
    localparam int PIX_W  = 8;
    localparam int LEVELS = 1 << PIX_W;

    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_WAIT,
        ST_COUNT,
        ST_BUILD
    } heq_state_t;
endpackage

// File: rtl/heq_ctrl.sv
module heq_ctrl
    import heq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [PIX_W-1:0] in_pix,
    output heq_state_t       state,
    output logic             cnt_en,
    output logic             cnt_bank,
    output logic             sweep_en,
    output logic             sweep_all,
    output logic             clr_bank,
    output logic [PIX_W-1:0] lvl,
    output logic             tbl_ok,
    output logic [PIX_W-1:0] pmax_apply
);
    localparam logic [PIX_W-1:0] LVL_MAX = {PIX_W{1'b1}};

    heq_state_t       nxt;
    logic             frame_end;
    logic             build_en;
    logic [PIX_W-1:0] pmax_run;
    logic [PIX_W-1:0] pmax_done;
    logic [PIX_W-1:0] cur_max;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CLEAR;
        else        state <= nxt;
    end

    // next state and strobes
    always_comb begin
        nxt       = state;
        cnt_en    = 1'b0;
        sweep_en  = 1'b0;
        sweep_all = 1'b0;
        build_en  = 1'b0;
        unique case (state)
            ST_CLEAR: begin
                sweep_en  = 1'b1;
                sweep_all = 1'b1;
                if (lvl == LVL_MAX) nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (in_valid && in_sof) begin
                    cnt_en = 1'b1;
                    nxt    = in_eof ? ST_BUILD : ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (in_valid) begin
                    cnt_en = 1'b1;
                    if (in_eof) nxt = ST_BUILD;
                end
            end
            ST_BUILD: begin
                sweep_en = 1'b1;
                build_en = 1'b1;
                if (lvl == LVL_MAX) nxt = ST_WAIT;
            end
            default: nxt = ST_CLEAR;
        endcase
    end

    assign frame_end = cnt_en && in_eof;
    assign cur_max   = ((state == ST_WAIT) || (in_pix > pmax_run)) ? in_pix : pmax_run;
    assign clr_bank  = ~cnt_bank;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl        <= '0;
            cnt_bank   <= 1'b0;
            tbl_ok     <= 1'b0;
            pmax_run   <= '0;
            pmax_done  <= '0;
            pmax_apply <= '0;
        end else begin
            if (sweep_en) lvl <= lvl + 1'b1;
            if (cnt_en)   pmax_run <= cur_max;
            if (frame_end) begin
                pmax_done <= cur_max;
                cnt_bank  <= ~cnt_bank;
            end
            if (build_en && (lvl == LVL_MAX)) begin
                tbl_ok     <= 1'b1;
                pmax_apply <= pmax_done;
            end
        end
    end
endmodule

// File: rtl/heq_hist_bank.sv
module heq_hist_bank
    import heq_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             cnt_en,
    input  logic             cnt_bank,
    input  logic [PIX_W-1:0] pix,
    input  logic             clr_en,
    input  logic             clr_all,
    input  logic             clr_bank,
    input  logic [PIX_W-1:0] lvl,
    output logic [CNT_W-1:0] rd_cnt
);
    localparam int BANKS = 2;

    logic [CNT_W-1:0] rd_b [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [CNT_W-1:0] mem [LEVELS];

        always_ff @(posedge clk) begin
            if (cnt_en && (cnt_bank == 1'(b)))
                mem[pix] <= mem[pix] + CNT_W'(1);
            else if (clr_en && (clr_all || (clr_bank == 1'(b))))
                mem[lvl] <= '0;
        end

        assign rd_b[b] = mem[lvl];
    end

    assign rd_cnt = rd_b[clr_bank];
endmodule

// File: rtl/heq_cdf_table.sv
module heq_cdf_table
    import heq_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  heq_state_t       state,
    input  logic [PIX_W-1:0] lvl,
    input  logic [CNT_W-1:0] hist_cnt,
    input  logic [PIX_W-1:0] rd_pix,
    output logic [CNT_W-1:0] rd_cdf
);
    logic [CNT_W-1:0] tbl [LEVELS];
    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] sum;
    logic             build_en;

    assign build_en = (state == ST_BUILD);
    assign sum      = ((lvl == '0) ? '0 : acc) + hist_cnt;

    always_ff @(posedge clk) begin
        if (build_en) begin
            tbl[lvl] <= sum;
            acc      <= sum;
        end
        rd_cdf <= tbl[rd_pix];
    end
endmodule

// File: rtl/heq_mapper.sv
module heq_mapper
    import heq_pkg::*;
#(
    parameter int PIXELS = 128,
    parameter int CNT_W  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             tbl_ok,
    input  logic [CNT_W-1:0] cdf_q,
    input  logic [PIX_W-1:0] pmax,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eof,
    output logic [PIX_W-1:0] out_pix
);
    localparam int PW   = CNT_W + PIX_W + 1;
    localparam int HALF = PIXELS / 2;

    logic             s1_valid, s1_sof, s1_eof, s1_pass;
    logic [PIX_W-1:0] s1_pix;
    logic [PW-1:0]    prod;
    logic [PW-1:0]    quot;
    logic [PIX_W-1:0] mapped;

    assign prod   = PW'(cdf_q) * PW'(pmax) + PW'(HALF);
    assign quot   = prod / PW'(PIXELS);
    assign mapped = (quot > PW'(LEVELS - 1)) ? {PIX_W{1'b1}} : quot[PIX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_sof    <= 1'b0;
            s1_eof    <= 1'b0;
            s1_pass   <= 1'b1;
            s1_pix    <= '0;
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_pix   <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_sof    <= in_valid && in_sof;
            s1_eof    <= in_valid && in_eof;
            s1_pass   <= !tbl_ok;
            s1_pix    <= in_pix;
            out_valid <= s1_valid;
            out_sof   <= s1_sof;
            out_eof   <= s1_eof;
            out_pix   <= s1_pass ? s1_pix : mapped;
        end
    end
endmodule

// File: rtl/hist_equalizer.sv
module hist_equalizer
    import heq_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int FRAME_H = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eof,
    output logic [PIX_W-1:0] out_pix
);
    localparam int PIXELS = FRAME_W * FRAME_H;
    localparam int CNT_W  = $clog2(PIXELS + 1) + 1;

    heq_state_t       st;
    logic             cnt_en, cnt_bank, sweep_en, sweep_all, clr_bank, tbl_ok;
    logic [PIX_W-1:0] lvl, pmax_apply;
    logic [CNT_W-1:0] hist_cnt, cdf_q;

    heq_ctrl ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_pix(in_pix),
        .state(st), .cnt_en(cnt_en), .cnt_bank(cnt_bank),
        .sweep_en(sweep_en), .sweep_all(sweep_all), .clr_bank(clr_bank),
        .lvl(lvl), .tbl_ok(tbl_ok), .pmax_apply(pmax_apply)
    );

    heq_hist_bank #(.CNT_W(CNT_W)) hist_i (
        .clk(clk), .cnt_en(cnt_en), .cnt_bank(cnt_bank), .pix(in_pix),
        .clr_en(sweep_en), .clr_all(sweep_all), .clr_bank(clr_bank),
        .lvl(lvl), .rd_cnt(hist_cnt)
    );

    heq_cdf_table #(.CNT_W(CNT_W)) cdf_i (
        .clk(clk), .state(st), .lvl(lvl), .hist_cnt(hist_cnt),
        .rd_pix(in_pix), .rd_cdf(cdf_q)
    );

    heq_mapper #(.PIXELS(PIXELS), .CNT_W(CNT_W)) map_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_pix(in_pix),
        .tbl_ok(tbl_ok), .cdf_q(cdf_q), .pmax(pmax_apply),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_pix(out_pix)
    );
endmodule

// File: rtl/heq_checker.sv
module heq_checker
    import heq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_sof,
    input logic [PIX_W-1:0] in_pix,
    input logic             out_valid,
    input logic             out_sof,
    input logic [PIX_W-1:0] out_pix,
    input heq_state_t       st,
    input logic             tbl_ok
);
    logic [8:0] sweep_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) sweep_cnt <= '0;
        else if ((st == ST_BUILD) || (st == ST_CLEAR)) sweep_cnt <= sweep_cnt + 9'd1;
        else sweep_cnt <= '0;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);

    p_no_phantom_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);

    p_sof_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> ##1 out_sof);

    p_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !tbl_ok) |=> ##1 (out_pix == $past(in_pix, 2)));

    p_build_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUILD && sweep_cnt < 9'd255) |=> (st == ST_BUILD));

    p_build_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BUILD && sweep_cnt == 9'd255) |=> (st == ST_WAIT));

    p_clear_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLEAR && sweep_cnt == 9'd255) |=> (st == ST_WAIT));

    p_stray_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT && !(in_valid && in_sof)) |=> (st == ST_WAIT));
endmodule

bind hist_equalizer heq_checker chk_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
    .out_valid(out_valid), .out_sof(out_sof), .out_pix(out_pix),
    .st(st), .tbl_ok(tbl_ok)
);

// File: tb/hist_equalizer_tb.sv
module hist_equalizer_tb_top;
    localparam int FW = 16;
    localparam int FH = 8;
    localparam int NPIX = FW * FH;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_pix = '0;
    logic       out_valid, out_sof, out_eof;
    logic [7:0] out_pix;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 1'b0;

    int prev_hist [256];
    int cur_hist  [256];
    int prev_pmax = 0;
    bit prev_ok   = 1'b0;

    int    q_pix [$];
    int    q_cyc [$];
    bit    q_sof [$];
    bit    q_eof [$];
    string q_tag [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hist_equalizer #(.FRAME_W(FW), .FRAME_H(FH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_pix(in_pix),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_pix(out_pix)
    );

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic int exp_map(int v);
        int c = 0;
        int q;
        if (!prev_ok) return v;
        for (int l = 0; l <= v; l++) c += prev_hist[l];
        q = (c * prev_pmax + NPIX / 2) / NPIX;
        return (q > 255) ? 255 : q;
    endfunction

    function automatic int pat_pix(int pat, int i);
        case (pat)
            0: return (i * 7 + 3) % 256;
            1: return (i * i * 13 + i * 5 + 17) % 256;
            2: return 100;
            3: return (i % 2 == 0) ? 10 : 50;
            default: return 200;
        endcase
    endfunction

    // output monitor: order, latency (R2) and value
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_pix.size() == 0) begin
                check("R2 unexpected output", 1, 0);
            end else begin
                string t;
                t = q_tag.pop_front();
                check({t, " pixel"}, int'(out_pix), q_pix.pop_front());
                check("R2 latency", cyc, q_cyc.pop_front());
                check("R2 sof", int'(out_sof), int'(q_sof.pop_front()));
                check("R2 eof", int'(out_eof), int'(q_eof.pop_front()));
            end
        end
    end

    task automatic drive(bit sof, bit eof, int pix, int exp, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_eof = eof; in_pix = 8'(pix);
        q_pix.push_back(exp);
        q_cyc.push_back(cyc + 2);
        q_sof.push_back(sof);
        q_eof.push_back(eof);
        q_tag.push_back(tag);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        end
    endtask

    task automatic run_frame(string tag, int pat, int len, int gap);
        int cmax = 0;
        for (int l = 0; l < 256; l++) cur_hist[l] = 0;
        for (int i = 0; i < len; i++) begin
            int p;
            p = pat_pix(pat, i);
            drive(i == 0, i == len - 1, p, exp_map(p), tag);
            cur_hist[p]++;
            if (p > cmax) cmax = p;
        end
        for (int l = 0; l < 256; l++) prev_hist[l] = cur_hist[l];
        prev_pmax = cmax;
        prev_ok   = 1'b1;
        idle(gap);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", int'(out_valid), 0);
        idle(300);
        check("R1 idle output after clear", int'(out_valid), 0);
    endtask

    task automatic t_passthru();
        run_frame("R3", 0, NPIX, 300);
    endtask

    task automatic t_mapping();
        run_frame("R4", 1, NPIX, 300);
        run_frame("R4", 2, NPIX, 256);
    endtask

    task automatic t_min_gap_scale();
        // mapped through a constant-100 frame right after minimum gap
        run_frame("R5,R9", 0, NPIX, 300);
    endtask

    task automatic t_bank_clear();
        run_frame("R6", 3, NPIX, 300);
    endtask

    task automatic t_stray();
        for (int i = 0; i < 20; i++) drive(1'b0, 1'b0, 0, exp_map(0), "R7 stray");
        idle(10);
        run_frame("R7", 0, NPIX, 300);
    endtask

    task automatic t_clamp();
        run_frame("R4", 4, NPIX * 3 / 2, 300);
        run_frame("R8", 0, NPIX, 300);
    endtask

    initial begin
        t_reset();
        t_passthru();
        t_mapping();
        t_min_gap_scale();
        t_bank_clear();
        t_stray();
        t_clamp();
        idle(10);
        check("R2 all outputs seen", q_pix.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule